// File: doc/BRIEF.md
# Color-Steered Gain Selector

This block decides, pixel by pixel, which of four small gain settings applies to the sample leaving an image sensor. The choice follows the sensor's color filter layout. Each clock is one pixel. The block keeps three pieces of state:

- a horizontal pixel counter,
- a line-type flag that flips from one line to the next,
- the active steering mode.

The counter restarts a fixed number of clocks after the line sync falls. The frame sync puts everything back at the first line type.

Two layouts are supported. In the mosaic layout, one kind of line alternates indices 0 and 1 and the other kind alternates 2 and 3. In the stripe layout, every line repeats 0, 1, 2. For each pixel the block registers the chosen 2-bit index together with the 6-bit gain value taken from a packed bank of four gain settings. The amplifier that consumes the value is not part of this block.

Top module: `csg_gain_steer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `gain_idx` and `gain_val` are 0. Reset selects the mosaic mode (`mode_sel` = 0) and the first line type.
- R2: A falling edge of `line_sync` is first seen at some rising edge E. The pixel counter restarts at rising edge E+5, which is the sixth edge that sees the low level. The index for pixel 0 of the new line appears on the outputs after edge E+6. Several falls closer together than this delay are each handled on their own.
- R3: In mosaic mode, `gain_idx` is `{line_type, pixel_count[0]}`. On a first-type line the indices run 0,1,0,1 from the restart. On a second-type line they run 2,3,2,3.
- R4: Each restart caused by `line_sync` alone flips the line type. Without a restart the line type holds, and the pixel counter advances by one per clock.
- R5: A falling edge of `frame_sync` goes through the same five-edge delay as `line_sync`. It restarts the counter and forces the first line type. It wins over a `line_sync` fall that lands in the same cycle.
- R6: In stripe mode (`mode_sel` = 1), `gain_idx` cycles 0,1,2 starting at 0 on every restart, whatever the line type. It never shows 3.
- R7: `mode_sel` is sampled only at a restart caused by `frame_sync`. A change at any other time has no effect on `gain_idx` until that point.
- R8: `gain_val` equals the 6-bit field `gain_regs[6*i+5:6*i]`, where i is the `gain_idx` shown in the same cycle. The field is taken from the `gain_regs` value present one edge earlier, so a gain write shows up after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_sync | input | 1 | Line sync, falling edge starts a line |
| frame_sync | input | 1 | Frame sync, falling edge starts a frame |
| mode_sel | input | 1 | 0 = mosaic layout, 1 = stripe layout (sampled at frame start) |
| gain_regs | input | 24 | Four packed 6-bit gain settings, setting i at bits [6i+5:6i] |
| gain_idx | output | 2 | Registered gain index for the current pixel |
| gain_val | output | 6 | Registered gain value selected by gain_idx |

## Verification
The bench targets the restart delay. A design that counts the edges wrong shifts every line's pattern by one pixel, and a mosaic line then starts on index 1 or 3. It sends two line-sync pulses only three clocks apart. A single-slot delay would drop the second restart and leave the line type wrong for the rest of the frame. It drops frame and line sync together, and a design with the wrong priority flips the line type instead of clearing it. It also changes the mode in the middle of a frame and writes gains in the middle of a line. These catch a mode that takes effect early and a gain value that lags or leads its index by a cycle.

// File: rtl/csg_pkg.sv
`timescale 1ns/1ps
package csg_pkg;

    localparam int unsigned NUM_GAINS = 4;
    localparam int unsigned IDX_W     = $clog2(NUM_GAINS);

    typedef enum logic {
        STEER_MOSAIC = 1'b0,
        STEER_STRIPE = 1'b1
    } steer_mode_e;

    typedef struct packed {
        logic [1:0]  ph3;
        logic        line_par;
        steer_mode_e mode;
    } steer_state_t;

    function automatic logic [1:0] ph3_advance(logic [1:0] ph);
        return (ph == 2'd2) ? 2'd0 : ph + 2'd1;
    endfunction

    function automatic logic [IDX_W-1:0] steer_index(steer_state_t st, logic cnt_lsb);
        if (st.mode == STEER_MOSAIC) begin
            return {st.line_par, cnt_lsb};
        end
        return st.ph3;
    endfunction

endpackage

// File: rtl/csg_edge_delay.sv
`timescale 1ns/1ps
module csg_edge_delay #(
    parameter int unsigned DLY = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic fire
);
    logic prev_q;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_in;
    end

    assign fall = prev_q & ~sync_in;

    generate
        if (DLY <= 1) begin : g_direct
            assign fire = fall;
        end else begin : g_pipe
            logic [DLY-2:0] sr_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr_q <= '0;
                end else begin
                    sr_q[0] <= fall;
                    for (int k = 1; k < int'(DLY) - 1; k++) begin
                        sr_q[k] <= sr_q[k-1];
                    end
                end
            end
            assign fire = sr_q[DLY-2];
        end
    endgenerate
endmodule

// File: rtl/csg_pixel_tracker.sv
`timescale 1ns/1ps
module csg_pixel_tracker
    import csg_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_fire,
    input  logic               v_fire,
    input  steer_mode_e        mode_in,
    output logic [CNT_W-1:0]   pix_cnt,
    output steer_state_t       state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_cnt        <= '0;
            state.ph3      <= 2'd0;
            state.line_par <= 1'b0;
            state.mode     <= STEER_MOSAIC;
        end else if (v_fire) begin
            pix_cnt        <= '0;
            state.ph3      <= 2'd0;
            state.line_par <= 1'b0;
            state.mode     <= mode_in;
        end else if (h_fire) begin
            pix_cnt        <= '0;
            state.ph3      <= 2'd0;
            state.line_par <= ~state.line_par;
        end else begin
            pix_cnt        <= pix_cnt + 1'b1;
            state.ph3      <= ph3_advance(state.ph3);
        end
    end
endmodule

// File: rtl/csg_gain_mux.sv
`timescale 1ns/1ps
module csg_gain_mux
    import csg_pkg::*;
#(
    parameter int unsigned GAIN_W = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [IDX_W-1:0]              idx_in,
    input  logic [NUM_GAINS*GAIN_W-1:0]   gain_regs,
    output logic [IDX_W-1:0]              idx_q,
    output logic [GAIN_W-1:0]             val_q
);
    logic [GAIN_W-1:0] bank [NUM_GAINS];

    generate
        for (genvar g = 0; g < int'(NUM_GAINS); g++) begin : g_bank
            assign bank[g] = gain_regs[g*GAIN_W +: GAIN_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            val_q <= '0;
        end else begin
            idx_q <= idx_in;
            val_q <= bank[idx_in];
        end
    end
endmodule

// File: rtl/csg_gain_steer.sv
`timescale 1ns/1ps
module csg_gain_steer
    import csg_pkg::*;
#(
    parameter int unsigned GAIN_W   = 6,
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned SYNC_DLY = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        line_sync,
    input  logic                        frame_sync,
    input  logic                        mode_sel,
    input  logic [NUM_GAINS*GAIN_W-1:0] gain_regs,
    output logic [IDX_W-1:0]            gain_idx,
    output logic [GAIN_W-1:0]           gain_val
);
    logic               h_fire;
    logic               v_fire;
    logic [CNT_W-1:0]   pix_cnt;
    steer_state_t       trk;
    logic               line_par;
    logic               act_mode;
    logic [IDX_W-1:0]   idx_next;

    csg_edge_delay #(.DLY(SYNC_DLY)) u_hdly (
        .clk(clk), .rst(rst), .sync_in(line_sync), .fire(h_fire)
    );

    csg_edge_delay #(.DLY(SYNC_DLY)) u_vdly (
        .clk(clk), .rst(rst), .sync_in(frame_sync), .fire(v_fire)
    );

    csg_pixel_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst(rst), .h_fire(h_fire), .v_fire(v_fire),
        .mode_in(steer_mode_e'(mode_sel)), .pix_cnt(pix_cnt), .state(trk)
    );

    assign line_par = trk.line_par;
    assign act_mode = trk.mode;
    assign idx_next = steer_index(trk, pix_cnt[0]);

    csg_gain_mux #(.GAIN_W(GAIN_W)) u_mux (
        .clk(clk), .rst(rst), .idx_in(idx_next), .gain_regs(gain_regs),
        .idx_q(gain_idx), .val_q(gain_val)
    );
endmodule

// File: rtl/csg_gain_steer_chk.sv
`timescale 1ns/1ps
module csg_gain_steer_chk #(
    parameter int unsigned GAIN_W = 6,
    parameter int unsigned CNT_W  = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic [4*GAIN_W-1:0]  gain_regs,
    input logic [1:0]           gain_idx,
    input logic [GAIN_W-1:0]    gain_val,
    input logic                 h_fire,
    input logic                 v_fire,
    input logic                 line_par,
    input logic                 act_mode,
    input logic [CNT_W-1:0]     pix_cnt
);
    function automatic logic [GAIN_W-1:0] pick(logic [4*GAIN_W-1:0] regs, logic [1:0] i);
        return regs[i*GAIN_W +: GAIN_W];
    endfunction

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (gain_idx == 2'd0 && gain_val == '0));

    // R2
    line_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (h_fire && !v_fire) |=> (pix_cnt == '0 && line_par != $past(line_par)));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!h_fire && !v_fire) |=> (pix_cnt == CNT_W'($past(pix_cnt) + 1'b1) && $stable(line_par)));

    // R5
    frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
        v_fire |=> (pix_cnt == '0 && !line_par));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !v_fire |=> $stable(act_mode));

    // R3
    mosaic_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(act_mode)) |-> (gain_idx == {$past(line_par), $past(pix_cnt[0])}));

    // R6
    stripe_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(act_mode)) |-> (gain_idx != 2'd3));

    // R8
    gain_pick_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (gain_val == pick($past(gain_regs), gain_idx)));
endmodule

bind csg_gain_steer csg_gain_steer_chk #(.GAIN_W(GAIN_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .gain_regs(gain_regs), .gain_idx(gain_idx),
    .gain_val(gain_val), .h_fire(h_fire), .v_fire(v_fire),
    .line_par(line_par), .act_mode(act_mode), .pix_cnt(pix_cnt)
);

// File: tb/csg_gain_steer_test.sv
`timescale 1ns/1ps
module csg_gain_steer_test;
    localparam int SYNC_DLY = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_sync = 1'b1;
    logic        frame_sync = 1'b1;
    logic        mode_sel = 1'b0;
    logic [23:0] gain_regs = '0;
    logic [1:0]  gain_idx;
    logic [5:0]  gain_val;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    csg_gain_steer uut (
        .clk(clk), .rst(rst), .line_sync(line_sync), .frame_sync(frame_sync),
        .mode_sel(mode_sel), .gain_regs(gain_regs),
        .gain_idx(gain_idx), .gain_val(gain_val)
    );

    always #2.5 clk = ~clk;

    // behavioural reference
    int m_edge = 0;
    int hq[$];
    int vq[$];
    bit m_hs_prev = 0, m_vs_prev = 0;
    int m_cnt = 0, m_ph = 0, m_par = 0, m_mode = 0;
    int exp_idx = 0, exp_val = 0;

    always @(posedge clk) begin
        bit hf, vf;
        m_edge++;
        if (rst) begin
            hq.delete(); vq.delete();
            m_hs_prev = 0; m_vs_prev = 0;
            m_cnt = 0; m_ph = 0; m_par = 0; m_mode = 0;
            exp_idx = 0; exp_val = 0;
        end else begin
            exp_idx = (m_mode == 0) ? (m_par * 2 + (m_cnt % 2)) : m_ph;
            exp_val = int'((gain_regs >> (exp_idx * 6)) & 24'h3f);
            if (m_hs_prev && !line_sync)  hq.push_back(m_edge);
            if (m_vs_prev && !frame_sync) vq.push_back(m_edge);
            m_hs_prev = line_sync;
            m_vs_prev = frame_sync;
            hf = 0; vf = 0;
            for (int i = hq.size() - 1; i >= 0; i--)
                if (m_edge - hq[i] == SYNC_DLY - 1) begin hf = 1; hq.delete(i); end
            for (int i = vq.size() - 1; i >= 0; i--)
                if (m_edge - vq[i] == SYNC_DLY - 1) begin vf = 1; vq.delete(i); end
            if (vf) begin
                m_par = 0; m_mode = int'(mode_sel); m_cnt = 0; m_ph = 0;
            end else if (hf) begin
                m_par = 1 - m_par; m_cnt = 0; m_ph = 0;
            end else begin
                m_cnt++; m_ph = (m_ph + 1) % 3;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (gain_idx !== 2'(exp_idx) || gain_val !== 6'(exp_val)) begin
                n_bad++;
                $display("FAIL %s t=%0t idx=%0d exp_idx=%0d val=%0d exp_val=%0d",
                         cur_req, $time, gain_idx, exp_idx, gain_val, exp_val);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_line(int len, int low_w, bit with_frame);
        @(negedge clk);
        line_sync = 1'b0;
        if (with_frame) frame_sync = 1'b0;
        idle(low_w);
        line_sync = 1'b1;
        frame_sync = 1'b1;
        idle(len - low_w);
    endtask

    initial begin
        gain_regs = {6'd44, 6'd33, 6'd22, 6'd11};
        cur_req = "R1";
        idle(4);
        rst = 1'b0;
        idle(3);

        cur_req = "R5/R2";
        send_line(30, 2, 1'b1);
        cur_req = "R3/R4";
        for (int i = 0; i < 4; i++) send_line(30, 3, 1'b0);

        cur_req = "R8";
        @(negedge clk) gain_regs = {6'd63, 6'd5, 6'd40, 6'd17};
        idle(7);
        gain_regs = {6'd1, 6'd2, 6'd3, 6'd4};
        idle(9);

        cur_req = "R7";
        mode_sel = 1'b1;
        for (int i = 0; i < 3; i++) send_line(29, 1, 1'b0);

        cur_req = "R6/R5";
        send_line(31, 2, 1'b1);
        cur_req = "R6";
        for (int i = 0; i < 3; i++) send_line(31 + i, 2, 1'b0);

        cur_req = "R2";
        send_line(3, 1, 1'b0);
        send_line(25, 1, 1'b0);

        cur_req = "R7/R5";
        mode_sel = 1'b0;
        send_line(20, 4, 1'b0);
        @(negedge clk) frame_sync = 1'b0;
        idle(3);
        frame_sync = 1'b1;
        idle(20);
        cur_req = "R3/R2";
        for (int i = 0; i < 3; i++) send_line(27, 2, 1'b0);

        cur_req = "R1";
        @(negedge clk) rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule